// File: doc/BRIEF.md
# Self-Programming Command Arming Register

This block is the control register a CPU uses to launch flash self-programming operations. Software writes a five-bit command pattern into the register. A store-program-memory strobe then follows, carrying a 16-bit Z pointer and a 16-bit data word. The block checks that the pattern is one of the accepted ones and opens a short arming window. If the strobe lands inside that window, the block turns the armed pattern into a command code. It sends the code, together with an address and a data word, to a flash back-end through a one-cycle start pulse.

There are five commands: buffer word load, page erase, page write, lock-bit set and read-section re-enable. Erase and write are long operations. While one of them runs, the register keeps its bits set and the CPU halt output stays asserted. Both clear only when the back-end reports done. The other commands clear the register as soon as they are issued. An arming that gets no strobe lapses by itself.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, and `cpu_halt` and `be_start` are low.
- R2: A register write is accepted only when `reg_wdata[4:0]` is exactly 00001, 00011, 00101, 01001 or 10001. An accepted write is visible on `reg_rdata[4:0]` in the following cycle. Bits 7:5 always read zero. Any other pattern leaves `reg_rdata` unchanged.
- R3: An accepted write arms the block for four cycles. A strobe sampled on any of the four clock edges after the write edge is accepted. Without a strobe, the register clears on the fourth edge, and a later strobe produces no start.
- R4: An accepted write made while the block is armed reloads the four-cycle window.
- R5: Pattern 00001 (enable only) issues command code 0, buffer load. The address is Z with bit 0 forced to 0, the data is the strobe data word, and the register reads 0 afterwards.
- R6: Pattern 00011 (bit 1, page erase) issues command code 1. The address is Z with its low PAGE_LG2 bits (default 7) cleared, and the data is 0.
- R7: Pattern 00101 (bit 2, page write) issues command code 2, with the same page address rule as R6 and data 0.
- R8: Pattern 01001 (bit 3, lock-bit set) issues command code 3 with address Z and the strobe data. Pattern 10001 (bit 4, read re-enable) issues command code 4 with address Z and data 0. Both clear the register on issue.
- R9: During an erase or a write, the register keeps its pattern and `cpu_halt` stays high. Both are set from the cycle after the strobe edge until the cycle after `be_done`, and then the register reads 0.
- R10: While an erase or write is in progress, or while `be_busy` is high, register writes and strobes are ignored.
- R11: `be_start` is a single-cycle pulse in the cycle after the accepted strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| spm_strobe | input | 1 | Store-program-memory strobe |
| z_ptr | input | 16 | Z pointer carried by the strobe |
| r_word | input | 16 | Data word carried by the strobe |
| be_start | output | 1 | One-cycle command start to back-end |
| be_cmd | output | 3 | Command code (0 load, 1 erase, 2 write, 3 lock, 4 re-enable) |
| be_addr | output | 16 | Command address |
| be_data | output | 16 | Command data word |
| be_busy | input | 1 | Back-end operation running |
| be_done | input | 1 | One-cycle completion pulse from back-end |
| cpu_halt | output | 1 | CPU halt during erase and write |

## Verification
The bench places strobes on every edge of the window and one edge past it, to catch an off-by-one window. An off-by-one window either accepts the late strobe or drops the fourth. It writes all 32 low patterns, so a decoder that accepts a near-miss such as 00111 leaves a wrong value in the register. It measures the exact length of the halt pulse against the back-end latency, and tries writes in the middle of an erase. A design that clears the enable on the strobe, or that lets a write through while the erase runs, shows up there as a wrong register value or a short halt. A window-reload case confirms that a second write extends arming past the first window's end.

// File: rtl/spm_cmd_pkg.sv
package spm_cmd_pkg;

  localparam int CTRL_W = 5;

  typedef enum logic [2:0] {
    CMD_LOAD  = 3'd0,
    CMD_ERASE = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LOCK  = 3'd3,
    CMD_RDEN  = 3'd4
  } spm_cmd_e;

  function automatic logic pattern_ok(input logic [CTRL_W-1:0] p);
    case (p)
      5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic spm_cmd_e pattern_cmd(input logic [CTRL_W-1:0] p);
    case (p)
      5'b00011: return CMD_ERASE;
      5'b00101: return CMD_WRITE;
      5'b01001: return CMD_LOCK;
      5'b10001: return CMD_RDEN;
      default:  return CMD_LOAD;
    endcase
  endfunction

  function automatic logic cmd_is_long(input spm_cmd_e c);
    return (c == CMD_ERASE) || (c == CMD_WRITE);
  endfunction

endpackage

// File: rtl/spm_pattern_decode.sv
module spm_pattern_decode
  import spm_cmd_pkg::*;
(
  input  logic [CTRL_W-1:0] wr_pat,
  input  logic [CTRL_W-1:0] arm_pat,
  output logic              wr_ok,
  output spm_cmd_e          arm_cmd,
  output logic              arm_long
);
  always_comb begin
    wr_ok    = pattern_ok(wr_pat);
    arm_cmd  = pattern_cmd(arm_pat);
    arm_long = cmd_is_long(arm_cmd);
  end
endmodule

// File: rtl/spm_arm_window.sv
module spm_arm_window #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic kill,
  output logic active,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= RELOAD;
    else if (kill)          cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  always_comb begin
    active = (cnt_q != '0);
    expire = (cnt_q == ONE) && !load && !kill;
  end
endmodule

// File: rtl/spm_issue.sv
module spm_issue
  import spm_cmd_pkg::*;
#(
  parameter int ZW       = 16,
  parameter int DW       = 16,
  parameter int PAGE_LG2 = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  spm_cmd_e      cmd,
  input  logic          is_long,
  input  logic [ZW-1:0] z,
  input  logic [DW-1:0] wd,
  input  logic          done,
  output logic          start,
  output logic [2:0]    cmd_o,
  output logic [ZW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          halt,
  output logic          long_busy
);
  localparam logic [ZW-1:0] PAGE_MASK = ~((ZW'(1) << PAGE_LG2) - ZW'(1));
  localparam logic [ZW-1:0] WORD_MASK = ~ZW'(1);

  logic [ZW-1:0] addr_n;
  logic [DW-1:0] data_n;

  always_comb begin
    case (cmd)
      CMD_LOAD:            addr_n = z & WORD_MASK;
      CMD_ERASE, CMD_WRITE: addr_n = z & PAGE_MASK;
      default:             addr_n = z;
    endcase
    data_n = (cmd == CMD_LOAD || cmd == CMD_LOCK) ? wd : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start     <= 1'b0;
      cmd_o     <= 3'd0;
      addr_o    <= '0;
      data_o    <= '0;
      halt      <= 1'b0;
      long_busy <= 1'b0;
    end else begin
      start <= fire;
      if (fire) begin
        cmd_o  <= cmd;
        addr_o <= addr_n;
        data_o <= data_n;
        if (is_long) begin
          halt      <= 1'b1;
          long_busy <= 1'b1;
        end
      end else if (long_busy && done) begin
        halt      <= 1'b0;
        long_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
  import spm_cmd_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int ZW         = 16,
  parameter int DW         = 16,
  parameter int PAGE_LG2   = 7,
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             spm_strobe,
  input  logic [ZW-1:0]    z_ptr,
  input  logic [DW-1:0]    r_word,
  output logic             be_start,
  output logic [2:0]       be_cmd,
  output logic [ZW-1:0]    be_addr,
  output logic [DW-1:0]    be_data,
  input  logic             be_busy,
  input  logic             be_done,
  output logic             cpu_halt
);
  localparam int PAD_W = REG_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ok, arm_long, long_busy;
  spm_cmd_e          arm_cmd;
  logic              win_active, win_expire;
  logic              accept_wr, fire, blocked;

  spm_pattern_decode u_dec (
    .wr_pat   (reg_wdata[CTRL_W-1:0]),
    .arm_pat  (ctrl_q),
    .wr_ok    (wr_ok),
    .arm_cmd  (arm_cmd),
    .arm_long (arm_long)
  );

  always_comb begin
    blocked   = be_busy || long_busy;
    accept_wr = reg_we && wr_ok && !blocked;
    fire      = spm_strobe && win_active && ctrl_q[0] && !blocked;
  end

  spm_arm_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk    (clk),
    .rst    (rst),
    .load   (accept_wr),
    .kill   (fire),
    .active (win_active),
    .expire (win_expire)
  );

  spm_issue #(.ZW(ZW), .DW(DW), .PAGE_LG2(PAGE_LG2)) u_iss (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .cmd       (arm_cmd),
    .is_long   (arm_long),
    .z         (z_ptr),
    .wd        (r_word),
    .done      (be_done),
    .start     (be_start),
    .cmd_o     (be_cmd),
    .addr_o    (be_addr),
    .data_o    (be_data),
    .halt      (cpu_halt),
    .long_busy (long_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)                        ctrl_q <= '0;
    else if (accept_wr)             ctrl_q <= reg_wdata[CTRL_W-1:0];
    else if (fire && !arm_long)     ctrl_q <= '0;
    else if (long_busy && be_done)  ctrl_q <= '0;
    else if (win_expire)            ctrl_q <= '0;
  end

  assign reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/spm_cmd_ctrl_chk.sv
module spm_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       spm_strobe,
  input logic       be_start,
  input logic       be_done,
  input logic       cpu_halt
);
  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    be_start |=> !be_start);

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !be_done) |=> cpu_halt);

  assert_halt_release_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && be_done) |=> (!cpu_halt && reg_rdata == 8'h00));

  assert_enable_held_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> reg_rdata[0]);

  assert_unarmed_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (spm_strobe && !reg_rdata[0]) |=> !be_start);

  assert_busy_write_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !be_done && reg_we) |=> $stable(reg_rdata));

  assert_legal_value_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata == 8'h00 || reg_rdata == 8'h01 || reg_rdata == 8'h03 ||
     reg_rdata == 8'h05 || reg_rdata == 8'h09 || reg_rdata == 8'h11));
endmodule

bind spm_cmd_ctrl spm_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_spm_cmd_ctrl.sv
module tb_spm_cmd_ctrl;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        spm_strobe = 1'b0;
  logic [15:0] z_ptr = '0, r_word = '0;
  logic        be_start;
  logic [2:0]  be_cmd;
  logic [15:0] be_addr, be_data;
  logic        be_busy, be_done, cpu_halt;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spm_cmd_ctrl dut (.*);

  // back-end stub: long ops run LAT cycles then pulse done
  int bcnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      be_busy <= 1'b0; be_done <= 1'b0; bcnt <= 0;
    end else begin
      be_done <= 1'b0;
      if (be_start && (be_cmd == 3'd1 || be_cmd == 3'd2)) begin
        be_busy <= 1'b1; bcnt <= LAT;
      end else if (bcnt > 1) begin
        bcnt <= bcnt - 1;
      end else if (bcnt == 1) begin
        bcnt <= 0; be_busy <= 1'b0; be_done <= 1'b1;
      end
    end
  end

  function automatic bit exp_ok(input logic [4:0] p);
    return p == 5'b00001 || p == 5'b00011 || p == 5'b00101 ||
           p == 5'b01001 || p == 5'b10001;
  endfunction

  function automatic logic [2:0] exp_cmd(input logic [4:0] p);
    case (p)
      5'b00011: return 3'd1;
      5'b00101: return 3'd2;
      5'b01001: return 3'd3;
      5'b10001: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input logic [2:0] c, input logic [15:0] z);
    case (c)
      3'd0:       return {z[15:1], 1'b0};
      3'd1, 3'd2: return {z[15:7], 7'b0};
      default:    return z;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(input logic [2:0] c, input logic [15:0] d);
    return (c == 3'd0 || c == 3'd3) ? d : 16'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] z, input logic [15:0] d);
    @(negedge clk); spm_strobe = 1'b1; z_ptr = z; r_word = d;
    @(negedge clk); spm_strobe = 1'b0;
  endtask

  // strobe with the bench's own negedge already consumed: use for d=0 delay
  task automatic strobe_now(input logic [15:0] z, input logic [15:0] d);
    spm_strobe = 1'b1; z_ptr = z; r_word = d;
    @(negedge clk); spm_strobe = 1'b0;
  endtask

  task automatic wait_halt(output int n);
    n = 0;
    while (cpu_halt && n < 100) begin n++; @(negedge clk); end
  endtask

  // full trial: write pat, wait d idle cycles, strobe, check
  task automatic trial(input logic [7:0] v, input int d, input logic [15:0] z, input logic [15:0] dw);
    logic [4:0] p; bit fire; logic [2:0] c; int n;
    p = v[4:0];
    wr(v);
    chk("R2 write", reg_rdata, exp_ok(p) ? {3'b0, p} : 8'h00);
    idle(d);
    strobe_now(z, dw);
    fire = exp_ok(p) && d <= 3;
    c = exp_cmd(p);
    chk("R3/R11 start", be_start, fire);
    if (fire) begin
      chk(c == 3'd0 ? "R5 cmd" : c == 3'd1 ? "R6 cmd" : c == 3'd2 ? "R7 cmd" : "R8 cmd", be_cmd, c);
      chk("R5-R8 addr", be_addr, exp_addr(c, z));
      chk("R5-R8 data", be_data, exp_data(c, dw));
      chk("R9 halt", cpu_halt, (c == 3'd1 || c == 3'd2));
      if (c == 3'd1 || c == 3'd2) begin
        chk("R9 held", reg_rdata, {3'b0, p});
        wait_halt(n);
        chk("R9 halt length", n, LAT + 2);
        chk("R9 cleared", reg_rdata, 8'h00);
      end else chk("R8 cleared", reg_rdata, 8'h00);
    end else begin
      chk("R3 lapsed", reg_rdata, 8'h00);
    end
    @(negedge clk);
    chk("R11 one pulse", be_start, 1'b0);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    idle(3);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 halt", cpu_halt, 1'b0);
    chk("R1 start", be_start, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R2: every low pattern, upper bits set
    for (int p = 0; p < 32; p++) begin
      wr({3'b111, p[4:0]});
      chk("R2 pattern", reg_rdata, exp_ok(p[4:0]) ? {3'b0, p[4:0]} : 8'h00);
      idle(5);
    end

    // R3 window edges
    for (int d = 0; d <= 5; d++) trial(8'h01, d, 16'h1235, 16'hbeef);

    // R4 reload
    wr(8'h01); idle(2); wr(8'h09); idle(2);
    strobe_now(16'h4321, 16'hcafe);
    chk("R4 reload start", be_start, 1'b1);
    chk("R4 reload cmd", be_cmd, 3'd3);

    // R5..R8 directed
    trial(8'h01, 0, 16'hffff, 16'h1234);
    trial(8'h03, 1, 16'hfedc, 16'h5555);
    trial(8'h05, 3, 16'h80ff, 16'h7777);
    trial(8'h09, 2, 16'h0f0f, 16'ha5a5);
    trial(8'h11, 0, 16'h3333, 16'h9999);

    // R10: writes and strobes during erase ignored
    wr(8'h03); strobe_now(16'h0200, 16'h0);
    chk("R10 erase started", cpu_halt, 1'b1);
    wr(8'h01);
    chk("R10 write ignored", reg_rdata, 8'h03);
    strobe(16'h0000, 16'h0);
    chk("R10 strobe ignored", be_start, 1'b0);
    wait_halt(n);
    chk("R10 end clear", reg_rdata, 8'h00);

    // random
    for (int i = 0; i < 300; i++) begin
      logic [7:0] v; int d;
      v = 8'($urandom);
      if ($urandom % 2 == 0) begin
        case ($urandom % 5)
          0: v[4:0] = 5'b00001; 1: v[4:0] = 5'b00011; 2: v[4:0] = 5'b00101;
          3: v[4:0] = 5'b01001; default: v[4:0] = 5'b10001;
        endcase
      end
      d = int'($urandom % 7);
      trial(v, d, 16'($urandom), 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule